// File: doc/BRIEF.md
# Serial Sensitivity and System Loader

This block sits in front of a two-channel call-charge tone detector and provides the configuration that both channels share. An external controller uses a three-wire port (active-low select, serial clock and serial data) to write a six-bit word. The first five bits shifted in form a band-pass gain code in 1 dB steps. The last bit picks the tone system: 1 selects 12 kHz and 0 selects 16 kHz. The block samples all pins on a fast system clock. It finds serial-clock rising edges in that clock domain and takes a new word into use only after the select line is released.

A strap input selects between two modes. When it is high, the block runs in fixed-sensitivity mode. The gain code presented is zero, the system bit comes straight from a system-select pin, and serial traffic is ignored. When the strap is low, the stored serial word drives both outputs. A gain code above the allowed maximum is clamped and sets a sticky error flag. A one-cycle strobe reports every change of the effective configuration.

Top module: `sens_loader`

## Requirements
- R1: After reset, gain_code is 0, sys_12k is 0, cfg_changed is 0 and code_err is 0. The stored word is gain 0 with the 16 kHz system.
- R2: In serial mode (preset_pin=0), a frame starts when csn_pin goes low. Six data bits are captured on serial-clock rising edges, MSB first. On csn_pin release, the first five bits become gain_code (first bit = gain bit 4) and the sixth becomes sys_12k (1 = 12 kHz, 0 = 16 kHz).
- R3: A frame with any number of captured edges other than six is discarded on release, and the outputs keep their previous values.
- R4: A new word does not reach the outputs while csn_pin is still low, even after all six bits have been shifted in.
- R5: A received gain field of 28 to 31 is presented as 27, and code_err is set. code_err stays 1 until reset, whatever frames follow.
- R6: With preset_pin=1, gain_code is 0 and sys_12k follows sys_pin (1 = 12 kHz). Frames sent in this mode change nothing, and the stored serial word returns when preset_pin goes back to 0.
- R7: cfg_changed is high for exactly one clock, in the same cycle that gain_code or sys_12k takes a new value. It stays low when a frame reloads an identical configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_pin | input | 1 | Serial select, active low, asynchronous |
| sclk_pin | input | 1 | Serial clock, data taken on its rising edge |
| sdat_pin | input | 1 | Serial data, MSB first |
| preset_pin | input | 1 | 1 = fixed-sensitivity mode, 0 = serial control |
| sys_pin | input | 1 | System select used in fixed mode, 1 = 12 kHz |
| gain_code | output | 5 | Effective band-pass gain code, dB |
| sys_12k | output | 1 | Effective system, 1 = 12 kHz, 0 = 16 kHz |
| cfg_changed | output | 1 | One-cycle strobe on a configuration change |
| code_err | output | 1 | Sticky flag: forbidden gain code received |

## Verification
The assertions assume that the serial pins move slowly relative to the system clock. Each serial-clock level must last several system cycles, data must settle before its rising edge, and the select line must stay low across the whole frame, so the synchronisers see every edge exactly once. The stimulus holds every serial-clock phase and select guard for at least three system clocks, and it changes data only while the serial clock is low. The strap and system pins are changed only between frames.

// File: rtl/sens_loader.sv
module sens_loader #(
  parameter int WORD_BITS   = 6,
  parameter int GAIN_LIMIT  = 27,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csn_pin,
  input  logic                 sclk_pin,
  input  logic                 sdat_pin,
  input  logic                 preset_pin,
  input  logic                 sys_pin,
  output logic [WORD_BITS-2:0] gain_code,
  output logic                 sys_12k,
  output logic                 cfg_changed,
  output logic                 code_err
);
  localparam int GW = WORD_BITS - 1;
  localparam int CW = $clog2(WORD_BITS + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(WORD_BITS);
  localparam logic [CW-1:0] CNT_SAT  = CW'(WORD_BITS + 1);
  localparam logic [GW-1:0] LIM      = GW'(GAIN_LIMIT);

  logic [SYNC_STAGES-1:0] csn_sr, sclk_sr, sdat_sr, pre_sr, sys_sr;
  logic csn_s, sclk_s, sdat_s, preset_s, sys_s;
  logic csn_q, sclk_q;
  logic [WORD_BITS-1:0] shreg;
  logic [CW-1:0] cnt;
  logic [GW-1:0] w_gain;
  logic w_sys;

  assign csn_s    = csn_sr[SYNC_STAGES-1];
  assign sclk_s   = sclk_sr[SYNC_STAGES-1];
  assign sdat_s   = sdat_sr[SYNC_STAGES-1];
  assign preset_s = pre_sr[SYNC_STAGES-1];
  assign sys_s    = sys_sr[SYNC_STAGES-1];

  wire sclk_rise = sclk_s & ~sclk_q;
  wire cs_rise   = csn_s & ~csn_q;
  wire commit    = cs_rise & ~preset_s & (cnt == CNT_FULL);
  wire over      = shreg[WORD_BITS-1:1] > LIM;

  wire [GW-1:0] eff_gain = preset_s ? '0 : w_gain;
  wire          eff_sys  = preset_s ? sys_s : w_sys;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_sr  <= '1;
      sclk_sr <= '0;
      sdat_sr <= '0;
      pre_sr  <= '1;
      sys_sr  <= '1;
      csn_q   <= 1'b1;
      sclk_q  <= 1'b0;
    end else begin
      csn_sr  <= {csn_sr[SYNC_STAGES-2:0], csn_pin};
      sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], sclk_pin};
      sdat_sr <= {sdat_sr[SYNC_STAGES-2:0], sdat_pin};
      pre_sr  <= {pre_sr[SYNC_STAGES-2:0], preset_pin};
      sys_sr  <= {sys_sr[SYNC_STAGES-2:0], sys_pin};
      csn_q   <= csn_s;
      sclk_q  <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (preset_s || csn_s) begin
      cnt <= '0;
    end else if (sclk_rise && cnt != CNT_SAT) begin
      shreg <= {shreg[WORD_BITS-2:0], sdat_s};
      cnt   <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_gain   <= '0;
      w_sys    <= 1'b0;
      code_err <= 1'b0;
    end else if (commit) begin
      w_gain <= over ? LIM : shreg[WORD_BITS-1:1];
      w_sys  <= shreg[0];
      if (over) code_err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_code   <= '0;
      sys_12k     <= 1'b0;
      cfg_changed <= 1'b0;
    end else begin
      gain_code   <= eff_gain;
      sys_12k     <= eff_sys;
      cfg_changed <= (eff_gain != gain_code) || (eff_sys != sys_12k);
    end
  end

  assert_word_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(w_gain) && $stable(w_sys));

  assert_gain_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gain_code <= LIM);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> code_err);

  assert_preset_zero_gain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    preset_s |=> gain_code == '0);

  assert_strobe_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_changed == ((gain_code != $past(gain_code)) || (sys_12k != $past(sys_12k))));
endmodule

// File: tb/test_sens_loader.sv
module test_sens_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn_pin = 1'b1, sclk_pin = 1'b0, sdat_pin = 1'b0;
  logic preset_pin = 1'b1, sys_pin = 1'b1;
  logic [4:0] gain_code;
  logic sys_12k, cfg_changed, code_err;

  int vectors = 0, bad = 0;
  int pulses = 0, high_cycles = 0;
  logic strobe_d = 1'b0;

  always #4 clk = ~clk;

  sens_loader i_sens_loader (
    .clk, .rst_n, .csn_pin, .sclk_pin, .sdat_pin, .preset_pin, .sys_pin,
    .gain_code, .sys_12k, .cfg_changed, .code_err
  );

  always @(negedge clk) begin
    if (cfg_changed) high_cycles++;
    if (cfg_changed && !strobe_d) pulses++;
    strobe_d <= cfg_changed;
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic frame(logic [7:0] val, int nbits, int hold_g, int hold_s);
    csn_pin = 1'b0;
    wait_clk(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdat_pin = val[i];
      wait_clk(3);
      sclk_pin = 1'b1;
      wait_clk(3);
      sclk_pin = 1'b0;
    end
    wait_clk(6);
    check("R4 gain before release", gain_code, hold_g);
    check("R4 sys before release", sys_12k, hold_s);
    csn_pin = 1'b1;
    wait_clk(10);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_clk(3);
    check("R1 gain", gain_code, 0);
    check("R1 sys", sys_12k, 0);
    check("R1 strobe", cfg_changed, 0);
    check("R1 err", code_err, 0);
    preset_pin = 1'b0;
    rst_n = 1'b1;
    wait_clk(8);
    check("R1 stored gain", gain_code, 0);
    check("R1 stored sys", sys_12k, 0);
  endtask

  initial begin
    int pg, ps, eg, es, ee;
    do_reset();
    pg = 0; ps = 0; ee = 0;
    for (int w = 0; w < 64; w++) begin
      eg = (w >> 1) > 27 ? 27 : (w >> 1);
      es = w & 1;
      if ((w >> 1) > 27) ee = 1;
      pulses = 0; high_cycles = 0;
      frame(8'(w), 6, pg, ps);
      check("R2 gain", gain_code, eg);
      check("R2 sys", sys_12k, es);
      check("R5 err", code_err, ee);
      check("R7 pulses", pulses, (eg != pg || es != ps) ? 1 : 0);
      check("R7 width", high_cycles, pulses);
      pg = eg; ps = es;
    end
    pulses = 0;
    frame(8'h15, 5, 27, 1);
    frame(8'h55, 7, 27, 1);
    frame(8'h00, 0, 27, 1);
    check("R3 gain kept", gain_code, 27);
    check("R3 sys kept", sys_12k, 1);
    check("R3 no strobe", pulses, 0);
    frame(8'h04, 6, 27, 1);
    check("R5 err sticky", code_err, 1);
    check("R2 after clamp", gain_code, 2);

    do_reset();
    check("R5 err cleared", code_err, 0);
    frame(8'h0B, 6, 0, 0);
    check("R2 gain 5", gain_code, 5);
    check("R2 sys 12k", sys_12k, 1);
    pulses = 0;
    sys_pin = 1'b0;
    preset_pin = 1'b1;
    wait_clk(8);
    check("R6 gain 0", gain_code, 0);
    check("R6 sys pin 0", sys_12k, 0);
    check("R7 mode strobe", pulses, 1);
    pulses = 0;
    frame(8'h3E, 6, 0, 0);
    check("R6 frame ignored", gain_code, 0);
    check("R6 no strobe", pulses, 0);
    sys_pin = 1'b1;
    wait_clk(8);
    check("R6 sys pin 1", sys_12k, 1);
    preset_pin = 1'b0;
    wait_clk(8);
    check("R6 word kept gain", gain_code, 5);
    check("R6 word kept sys", sys_12k, 1);
    pulses = 0;
    frame(8'h0B, 6, 5, 1);
    check("R7 same word no strobe", pulses, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule